// File: doc/BRIEF.md
# Moving Inversions Stride Memory Tester

This engine runs a bitwise moving-inversions test over a window of a RAM of 32-bit words. It drives a single-port synchronous memory interface whose read data arrives one cycle after the request. After a pulse on `start` it first clears every word of the window. It then walks the window many times, each time with a different address order. Within each order it raises the bits of every visited word one at a time, and then lowers them one at a time. Every word is checked before and after each single-bit change.

The address order is set by a power-of-two stride. The stride begins at one word (4 bytes) and doubles after each full sweep. For a given stride, every word offset inside the stride serves in turn as the starting point of a sweep. The stride that ends the test is the `MAX_STRIDE` parameter, so a small simulation can use a short schedule.

The first mismatch halts the engine. It then raises `done` and `err` and reports which bits disagreed. A clean run raises `done` alone and leaves every word of the window at zero.

Top module: `mi_stride_tester`

## Requirements
- R1: During and just after reset, `done`, `err` and `err_mask` are zero and no memory request is issued.
- R2: After `start`, every word from `base_addr` up to (but not including) `end_addr` is written with zero, in ascending address order, before the first read is issued.
- R3: Sweeps use a stride of 4 bytes first. The stride doubles after all its offsets are done, and only strides below `MAX_STRIDE` are run.
- R4: For a stride s, the offsets 0, 4, 8 ... s-4 are taken in ascending order. Each one starts its sweeps at `base_addr`+offset and steps by s while the address is below `end_addr`.
- R5: For each offset, a raise phase handles bit 0 to bit 31 in order. The value written during the sweep of bit b is the expected value with bit b set. The expected value starts at zero and becomes the written value when the sweep for that bit ends.
- R6: A lower phase follows the raise phase in the same way. It starts from an expected value of all ones and writes the expected value with bit b cleared.
- R7: Each visit is a read, a compare with the expected value, a write, a read back of the same word and a compare with the written value. Read data is taken one cycle after the read request, and two reads are never issued in consecutive cycles.
- R8: On the first mismatch the engine stops issuing requests and raises `done` and `err`. `err_mask` then holds the observed word XOR the expected word, which is non-zero.
- R9: A run without a mismatch ends with `done` high, `err` low and `err_mask` zero, and leaves every word of the window at zero.
- R10: Every request is word aligned and lies inside [`base_addr`, `end_addr`). An empty window finishes without any request.
- R11: `done`, `err` and `err_mask` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or finished) |
| base_addr | input | ADDR_W | First byte address of the window, word aligned |
| end_addr | input | ADDR_W | Byte address one past the window, word aligned |
| mem_en | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (read when low) |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid one cycle after a read request |
| done | output | 1 | Run finished |
| err | output | 1 | Run stopped on a mismatch |
| err_mask | output | WORD_W | Observed XOR expected at the mismatch |

## Verification
A scoreboard predicts the write sequence as address and data pairs: the zero fill, every stride and offset, and both bit phases. Each write the engine issues is compared with this prediction. A wrong stride doubling, a skipped offset, a bit order error or an expected value that fails to carry from bit to bit therefore shows up as a wrong write. The bench injects three faults into its memory model: a bit stuck high, a bit stuck low and a write that also lands on a later word. A design that compared against the wrong reference, skipped the read back or reported the wrong mask would stop at the wrong point or report a different mask. Odd-sized and empty windows exercise the exclusive end bound and the case where a sweep has no addresses. A design that went one word past the end would touch memory outside the window.

// File: rtl/mi_stride_pkg.sv
// Shared types for the moving-inversions stride tester.
// Assumes: nothing beyond IEEE 1800-2017.
package mi_stride_pkg;

    // Sequencer states of the engine.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_SWEEP,
        ST_RD_PRE,
        ST_CMP_PRE,
        ST_RD_POST,
        ST_CMP_POST,
        ST_BIT_END,
        ST_FIN
    } mi_state_e;

    // Byte distance between consecutive words.
    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/mi_pattern_gen.sv
// Pattern generator: tracks the phase (raise or lower), the current bit and
// the expected word content, and forms the value to write for this bit.
// Assumes: bit_adv is pulsed once when the sweep for the current bit ends.
module mi_pattern_gen #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              bit_adv,
    output logic [WORD_W-1:0] exp_word,
    output logic [WORD_W-1:0] wr_word,
    output logic              pat_last
);
    localparam int IW = $clog2(WORD_W);
    localparam logic [IW-1:0] LAST_BIT = IW'(WORD_W - 1);

    logic              lower_q;
    logic [IW-1:0]     bit_q;
    logic [WORD_W-1:0] exp_q;
    logic [WORD_W-1:0] bit_sel;

    // Form the one-hot bit and the value written during this bit's sweep.
    always_comb begin
        bit_sel  = {{(WORD_W-1){1'b0}}, 1'b1} << bit_q;
        wr_word  = lower_q ? (exp_q & ~bit_sel) : (exp_q | bit_sel);
        exp_word = exp_q;
        pat_last = lower_q && (bit_q == LAST_BIT);
    end

    // Step through the bits of both phases and carry the expected value.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            lower_q <= 1'b0;
            bit_q   <= '0;
            exp_q   <= '0;
        end else if (bit_adv) begin
            if (bit_q == LAST_BIT) begin
                bit_q <= '0;
                if (lower_q) begin
                    lower_q <= 1'b0;
                    exp_q   <= '0;
                end else begin
                    lower_q <= 1'b1;
                    exp_q   <= '1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
                exp_q <= wr_word;
            end
        end
    end

endmodule

// File: rtl/mi_addr_walker.sv
// Address walker: holds the current address, the stride and the offset
// inside the stride, and reports where the walk stands against the window.
// Assumes: base and end are word aligned and stable during a run;
// MAX_STRIDE is a power of two no larger than 2**ADDR_W.
module mi_addr_walker #(
    parameter int ADDR_W     = 24,
    parameter int MAX_STRIDE = 32'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              fill_step,
    input  logic              sweep_load,
    input  logic              addr_step,
    input  logic              off_adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_in_range,
    output logic              next_in_range,
    output logic              strides_done
);
    import mi_stride_pkg::*;

    localparam int XW = ADDR_W + 1;
    localparam logic [XW-1:0] STEP  = XW'(WORD_BYTES);
    localparam logic [XW-1:0] LIMIT = XW'(MAX_STRIDE);

    logic [XW-1:0] cur_q;
    logic [XW-1:0] stride_q;
    logic [XW-1:0] off_q;
    logic [XW-1:0] end_x;
    logic [XW-1:0] next_x;

    // Range checks against the exclusive end bound, one bit wider to avoid wrap.
    always_comb begin
        end_x         = {1'b0, end_addr};
        next_x        = cur_q + stride_q;
        cur_in_range  = cur_q < end_x;
        next_in_range = next_x < end_x;
        strides_done  = stride_q >= LIMIT;
        cur_addr      = cur_q[ADDR_W-1:0];
    end

    // Advance address, offset and stride as the sequencer asks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            stride_q <= STEP;
            off_q    <= '0;
        end else if (init) begin
            cur_q    <= {1'b0, base_addr};
            stride_q <= STEP;
            off_q    <= '0;
        end else begin
            if (fill_step) begin
                cur_q <= cur_q + STEP;
            end else if (sweep_load) begin
                cur_q <= {1'b0, base_addr} + off_q;
            end else if (addr_step) begin
                cur_q <= next_x;
            end
            if (off_adv) begin
                if (off_q + STEP == stride_q) begin
                    off_q    <= '0;
                    stride_q <= stride_q << 1;
                end else begin
                    off_q <= off_q + STEP;
                end
            end
        end
    end

endmodule

// File: rtl/mi_word_cmp.sv
// Word comparator: forms the bitwise difference between the word read and
// the word expected, and flags any difference.
// Assumes: the inputs are valid in the cycle in which the caller uses miss.
module mi_word_cmp #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] observed,
    input  logic [WORD_W-1:0] expected,
    output logic [WORD_W-1:0] diff,
    output logic              miss
);
    // Bitwise difference and its reduction.
    always_comb begin
        diff = observed ^ expected;
        miss = |diff;
    end

endmodule

// File: rtl/mi_stride_tester.sv
// Moving-inversions stride tester top: zero-fills the window, then runs a
// raise phase and a lower phase per stride offset, checking each word before
// and after every single-bit write, and stops on the first mismatch.
// Assumes: one-cycle read latency on the memory port; base and end word
// aligned and held stable while a run is in progress.
module mi_stride_tester #(
    parameter int ADDR_W     = 24,
    parameter int WORD_W     = 32,
    parameter int MAX_STRIDE = 32'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] err_mask
);
    import mi_stride_pkg::*;

    mi_state_e         state_q, state_d;
    logic              run_init;
    logic              fill_step, sweep_load, addr_step, off_adv, bit_adv;
    logic              cur_in_range, next_in_range, strides_done;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] exp_word, wr_word, cmp_ref, cmp_diff;
    logic              pat_last, cmp_miss;
    logic              hit_err, hit_end;
    logic              done_q, err_q;
    logic [WORD_W-1:0] mask_q;

    mi_addr_walker #(
        .ADDR_W    (ADDR_W),
        .MAX_STRIDE(MAX_STRIDE)
    ) walk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .init         (run_init),
        .base_addr    (base_addr),
        .end_addr     (end_addr),
        .fill_step    (fill_step),
        .sweep_load   (sweep_load),
        .addr_step    (addr_step),
        .off_adv      (off_adv),
        .cur_addr     (cur_addr),
        .cur_in_range (cur_in_range),
        .next_in_range(next_in_range),
        .strides_done (strides_done)
    );

    mi_pattern_gen #(
        .WORD_W(WORD_W)
    ) pat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (run_init),
        .bit_adv (bit_adv),
        .exp_word(exp_word),
        .wr_word (wr_word),
        .pat_last(pat_last)
    );

    mi_word_cmp #(
        .WORD_W(WORD_W)
    ) cmp_i (
        .observed(mem_rdata),
        .expected(cmp_ref),
        .diff    (cmp_diff),
        .miss    (cmp_miss)
    );

    // Pick the compare reference: pre-write value or the value just written.
    always_comb begin
        cmp_ref = (state_q == ST_CMP_POST) ? wr_word : exp_word;
    end

    // Sequencer: memory requests, walker and pattern controls, next state.
    always_comb begin
        state_d    = state_q;
        run_init   = 1'b0;
        fill_step  = 1'b0;
        sweep_load = 1'b0;
        addr_step  = 1'b0;
        off_adv    = 1'b0;
        bit_adv    = 1'b0;
        hit_err    = 1'b0;
        hit_end    = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (start) begin
                    run_init = 1'b1;
                    state_d  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (cur_in_range) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    fill_step = 1'b1;
                end else begin
                    state_d = ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (strides_done) begin
                    hit_end = 1'b1;
                    state_d = ST_FIN;
                end else begin
                    sweep_load = 1'b1;
                    state_d    = ST_RD_PRE;
                end
            end
            ST_RD_PRE: begin
                if (cur_in_range) begin
                    mem_en  = 1'b1;
                    state_d = ST_CMP_PRE;
                end else begin
                    state_d = ST_BIT_END;
                end
            end
            ST_CMP_PRE: begin
                if (cmp_miss) begin
                    hit_err = 1'b1;
                    state_d = ST_FIN;
                end else begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = wr_word;
                    state_d   = ST_RD_POST;
                end
            end
            ST_RD_POST: begin
                mem_en  = 1'b1;
                state_d = ST_CMP_POST;
            end
            ST_CMP_POST: begin
                if (cmp_miss) begin
                    hit_err = 1'b1;
                    state_d = ST_FIN;
                end else if (next_in_range) begin
                    addr_step = 1'b1;
                    state_d   = ST_RD_PRE;
                end else begin
                    state_d = ST_BIT_END;
                end
            end
            ST_BIT_END: begin
                bit_adv = 1'b1;
                off_adv = pat_last;
                state_d = ST_SWEEP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Memory address always follows the walker.
    always_comb begin
        mem_addr = cur_addr;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers: cleared on a new run, captured at the finish.
    always_ff @(posedge clk) begin
        if (!rst_n || run_init) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            mask_q <= '0;
        end else if (hit_err) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            mask_q <= cmp_diff;
        end else if (hit_end) begin
            done_q <= 1'b1;
        end
    end

    assign done     = done_q;
    assign err      = err_q;
    assign err_mask = mask_q;

endmodule

// File: rtl/mi_stride_tester_chk.sv
// Protocol checker for the moving-inversions stride tester, attached by bind.
// Assumes: base and end held stable while a run is in progress.
module mi_stride_tester_chk #(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] end_addr,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              err,
    input logic [WORD_W-1:0] err_mask
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !err && err_mask == '0 && !mem_en));

    // R10
    window_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr >= base_addr && mem_addr < end_addr && mem_addr[1:0] == 2'b00));

    // R7
    spaced_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !(mem_en && !mem_we));

    // R8
    silent_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    // R8
    err_mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && err_mask != '0));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err) && $stable(err_mask)));

endmodule

bind mi_stride_tester mi_stride_tester_chk #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .base_addr(base_addr),
    .end_addr (end_addr),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .err      (err),
    .err_mask (err_mask)
);

// File: tb/mi_stride_tester_tb_top.sv
// Scoreboard bench: a driver task predicts every write (address, data), a
// monitor pops and compares each write the engine issues.
module mi_stride_tester_tb_top;

    localparam int AW    = 8;
    localparam int WW    = 32;
    localparam int MAXS  = 32;
    localparam int NWORD = 64;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [WW-1:0] d;
    } wr_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata;
    logic          done, err;
    logic [WW-1:0] err_mask;

    int total = 0;
    int bad = 0;

    logic [WW-1:0] ram [NWORD];
    logic [WW-1:0] rd_q = '0;
    int fault_kind = 0;   // 0 none, 1 bit stuck high, 2 bit stuck low, 3 aliased write
    int fault_word = 0;
    int fault_bit = 0;
    int alias_dst = 0;

    wr_item_t exp_q[$];
    bit mon_on = 1'b0;
    int n_wr = 0;
    int n_rd = 0;
    int first_rd_at = -1;
    int busy_after_done = 0;

    always #4 clk = ~clk;

    mi_stride_tester #(
        .ADDR_W    (AW),
        .WORD_W    (WW),
        .MAX_STRIDE(MAXS)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .base_addr(base_addr),
        .end_addr (end_addr),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .done     (done),
        .err      (err),
        .err_mask (err_mask)
    );

    function automatic logic [WW-1:0] faulty_read(logic [WW-1:0] v, int w);
        if (fault_kind == 1 && w == fault_word) return v | (32'h1 << fault_bit);
        if (fault_kind == 2 && w == fault_word) return v & ~(32'h1 << fault_bit);
        return v;
    endfunction

    // Memory model with one-cycle read latency and optional faults.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                ram[mem_addr[AW-1:2]] <= mem_wdata;
                if (fault_kind == 3 && int'(mem_addr[AW-1:2]) == fault_word)
                    ram[alias_dst] <= mem_wdata;
            end else begin
                rd_q <= faulty_read(ram[mem_addr[AW-1:2]], int'(mem_addr[AW-1:2]));
            end
        end
    end
    assign mem_rdata = rd_q;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Driver: predict the full write sequence for a window (R2 to R6).
    task automatic push_expect(input int lo, input int hi);
        for (int a = lo; a < hi; a += 4) exp_q.push_back('{a: AW'(a), d: '0});
        for (int s = 4; s < MAXS; s *= 2) begin
            for (int off = 0; off < s; off += 4) begin
                for (int ph = 0; ph < 2; ph++) begin
                    logic [WW-1:0] e;
                    e = (ph == 1) ? '1 : '0;
                    for (int b = 0; b < WW; b++) begin
                        logic [WW-1:0] nv;
                        nv = (ph == 1) ? (e & ~(32'h1 << b)) : (e | (32'h1 << b));
                        for (int a = lo + off; a < hi; a += s)
                            exp_q.push_back('{a: AW'(a), d: nv});
                        e = nv;
                    end
                end
            end
        end
    endtask

    // Monitor: compare each write against the scoreboard, watch the window.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done && mem_en) busy_after_done++;
            if (mem_en) begin
                chk(mem_addr >= base_addr && mem_addr < end_addr && mem_addr[1:0] == 2'b00,
                    "R10", "access in window", WW'(mem_addr), WW'(base_addr));
                if (mem_we) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3", "unexpected extra write", WW'(mem_addr), '0);
                    end else begin
                        wr_item_t it;
                        it = exp_q.pop_front();
                        chk(mem_addr == it.a, "R4", "write address", WW'(mem_addr), WW'(it.a));
                        chk(mem_wdata == it.d, "R5", "write data", mem_wdata, it.d);
                    end
                    n_wr++;
                end else begin
                    if (first_rd_at < 0) first_rd_at = n_wr;
                    n_rd++;
                end
            end
        end
    end

    task automatic run_case(input int lo, input int hi, input int kind, input int fw,
                            input int fb, input int ad, input bit exp_err,
                            input logic [WW-1:0] exp_mask, input string tag);
        int nw;
        nw = (hi > lo) ? (hi - lo) / 4 : 0;
        for (int i = 0; i < NWORD; i++) ram[i] = 32'hC3C3_0000 + i;
        fault_kind = kind; fault_word = fw; fault_bit = fb; alias_dst = ad;
        base_addr = AW'(lo); end_addr = AW'(hi);
        exp_q.delete();
        push_expect(lo, hi);
        n_wr = 0; n_rd = 0; first_rd_at = -1; busy_after_done = 0;
        mon_on = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        // R11: results held with no new start
        chk(done == 1'b1, "R11", {tag, " done held"}, WW'(done), 1);
        chk(busy_after_done == 0, "R8", {tag, " no access after done"}, busy_after_done, 0);
        chk(err == exp_err, exp_err ? "R8" : "R9", {tag, " err flag"}, WW'(err), WW'(exp_err));
        chk(err_mask == exp_mask, exp_err ? "R8" : "R9", {tag, " err mask"}, err_mask, exp_mask);
        if (nw > 0)
            chk(first_rd_at == nw, "R2", {tag, " fill before reads"}, first_rd_at, nw);
        if (!exp_err) begin
            int mw;
            chk(exp_q.size() == 0, "R3", {tag, " all predicted writes seen"}, exp_q.size(), 0);
            chk(n_rd == 2 * (n_wr - nw), "R7", {tag, " two reads per write"}, n_rd, 2 * (n_wr - nw));
            mw = 0;
            for (int i = 0; i < NWORD; i++) begin
                if (i >= lo / 4 && i < hi / 4) begin
                    if (ram[i] != '0) mw++;
                end else if (ram[i] != 32'hC3C3_0000 + i) begin
                    mw++;
                end
            end
            chk(mw == 0, "R9", {tag, " window zero, outside untouched"}, mw, 0);
        end
        mon_on = 1'b0;
        fault_kind = 0;
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0 && err == 1'b0, "R1", "flags in reset", {30'd0, done, err}, 0);
        chk(err_mask == '0, "R1", "mask in reset", err_mask, 0);
        chk(mem_en == 1'b0, "R1", "no request in reset", WW'(mem_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && mem_en == 1'b0, "R1", "idle after reset", {30'd0, done, mem_en}, 0);

        // Clean window of 16 words: strides 4, 8, 16 (R3, R4, R5, R6, R9)
        run_case(0, 64, 0, 0, 0, 0, 1'b0, '0, "clean16");
        // Odd-sized window: exclusive end, uneven offsets (R4, R10)
        run_case(32, 44, 0, 0, 0, 0, 1'b0, '0, "clean3");
        // Empty window: no request at all (R10)
        run_case(64, 64, 0, 0, 0, 0, 1'b0, '0, "empty");
        chk(n_wr + n_rd == 0, "R10", "empty window accesses", n_wr + n_rd, 0);
        // Bit 5 of word 3 stuck high: caught on the first pre-write read (R8)
        run_case(0, 64, 1, 3, 5, 0, 1'b1, 32'h0000_0020, "stuck_hi");
        // Bit 7 of word 2 stuck low: caught on read back of bit 7 (R7, R8)
        run_case(0, 64, 2, 2, 7, 0, 1'b1, 32'h0000_0080, "stuck_lo");
        // Writes to word 1 also land on word 3: caught in the bit 0 sweep (R8)
        run_case(0, 64, 3, 1, 0, 3, 1'b1, 32'h0000_0001, "alias");
        // Back to a clean run after faults (R9, R11 restart)
        run_case(16, 48, 0, 0, 0, 0, 1'b0, '0, "clean8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule